// File: doc/BRIEF.md
# Selectable-Latency SRAM Port Read Path

This block is the data path of one port of a synchronous static RAM. A port presents a command (address, write flag, write data and a set of lane write enables) together with two chip selects, and the block either writes the selected 9-bit lanes into a small on-chip array or reads a whole word back. The read data, a matching valid flag and the bus drive enable come out after a read latency that the integrator picks at reset: one clock edge (flow-through) or two clock edges (pipelined, one extra register stage).

A command only takes effect while both chip selects are high. The chip-select state is also delayed by the selected latency before it drives the bus enable, so the bus turns on and off in step with the data it carries. The output enable acts immediately, without a register. When no read completes, the data registers keep their contents and do not toggle, which saves power while the port is deselected.

Top module: `port_read_pipe`

## Requirements
- R1: The latency mode is taken from `pipe_sel` while `rst` is high (0 = flow-through, 1 = pipelined); changes of `pipe_sel` after reset has been released have no effect on latency.
- R2: In flow-through mode, a read sampled at clock edge k gives `rvalid` = 1 and the addressed word on `rdata` after edge k, for one cycle per read.
- R3: In pipelined mode, a read sampled at edge k gives `rvalid` = 1 and the addressed word on `rdata` after edge k+1. Back-to-back reads come out back to back.
- R4: A command is carried out only when `cs_a` and `cs_b` are both 1. With either one low, a write leaves the array unchanged and a read produces no `rvalid`.
- R5: `dq_oe` follows the logical AND of the two chip selects, delayed by the selected latency (1 edge flow-through, 2 edges pipelined), in both the enabling and the disabling direction, while `oe` is 1.
- R6: `oe` = 0 forces `dq_oe` to 0 at once, in the same cycle, without waiting for a clock edge.
- R7: A write stores only the lanes whose `lane_we` bit is 1; lane i is `wdata[9*i+8:9*i]` and is controlled by `lane_we[i]`. Other lanes keep their old contents.
- R8: A read returns all lanes of the addressed word, whatever `lane_we` holds at the time.
- R9: `rdata` holds its last value in every cycle where `rvalid` is 0.
- R10: During and right after reset, `rvalid` = 0, `dq_oe` = 0 and `rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, all registers on the rising edge |
| rst | input | 1 | Synchronous active-high reset; latency mode captured while high |
| pipe_sel | input | 1 | Latency choice: 0 flow-through, 1 pipelined |
| cs_a | input | 1 | First chip select, active high |
| cs_b | input | 1 | Second chip select, active high |
| oe | input | 1 | Output enable, gates `dq_oe` without a register |
| wr | input | 1 | 1 = write command, 0 = read command |
| addr | input | AW (6) | Word address |
| wdata | input | LANES*LANE_W (72) | Write data, lane i in bits 9i+8..9i |
| lane_we | input | LANES (8) | Per-lane write enable |
| rdata | output | LANES*LANE_W (72) | Read data, aligned with `rvalid` |
| rvalid | output | 1 | Read data valid, one cycle per read |
| dq_oe | output | 1 | Bus drive enable: delayed chip selects AND `oe` |

## Verification
A read sampled at edge k is due on `rdata`/`rvalid` one edge later in flow-through mode and two edges later in pipelined mode, so the driver stamps each expected word with the cycle it must appear in and the monitor, sampling on the falling edge, flags both early, late and unexpected valid data. The bus enable is checked cycle by cycle after a chip-select change, expecting the change exactly at the latency count and not before, while the output enable is checked a fraction of a cycle after it falls, before any clock edge. Both modes are exercised after separate resets, with the mode input flipped after each release to show it is ignored.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic {
    LAT_FLOW = 1'b0,
    LAT_PIPE = 1'b1
  } lat_mode_e;
endpackage

// File: rtl/bit_delay.sv
module bit_delay #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output logic [STAGES-1:0] taps
);
  always_ff @(posedge clk) begin
    if (rst) taps[0] <= 1'b0;
    else     taps[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) taps[k] <= 1'b0;
      else     taps[k] <= taps[k-1];
    end
  end
endmodule

// File: rtl/lane_ram.sv
module lane_ram #(
  parameter int AW = 6,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // output register: sync reset, load only on a read so it idles quietly
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= mem[addr];
  end
endmodule

// File: rtl/port_read_pipe.sv
module port_read_pipe
  import rdp_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 9,
  parameter int AW     = 6,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pipe_sel,
  input  logic             cs_a,
  input  logic             cs_b,
  input  logic             oe,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] lane_we,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  output logic             dq_oe
);
  localparam int MAX_LAT = 2;

  lat_mode_e        mode_q;
  logic             sel;
  logic             rd_fire;
  logic             wr_fire;
  logic [DW-1:0]    stage1;
  logic [DW-1:0]    stage2;
  logic [MAX_LAT-1:0] v_taps;
  logic [MAX_LAT-1:0] c_taps;
  logic             ce_del;

  // latency mode captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) mode_q <= lat_mode_e'(pipe_sel);
  end

  assign sel     = cs_a & cs_b;
  assign rd_fire = sel & ~wr;
  assign wr_fire = sel & wr;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_ram #(.AW(AW), .W(LANE_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_fire & lane_we[i]),
      .rd_en (rd_fire),
      .addr  (addr),
      .wdata (wdata[i*LANE_W +: LANE_W]),
      .rdata (stage1[i*LANE_W +: LANE_W])
    );
  end

  bit_delay #(.STAGES(MAX_LAT)) u_vdel (
    .clk (clk), .rst (rst), .din (rd_fire), .taps (v_taps)
  );

  bit_delay #(.STAGES(MAX_LAT)) u_cdel (
    .clk (clk), .rst (rst), .din (sel), .taps (c_taps)
  );

  // extra pipeline stage, loaded only when the first stage holds fresh data
  always_ff @(posedge clk) begin
    if (rst)            stage2 <= '0;
    else if (v_taps[0]) stage2 <= stage1;
  end

  always_comb begin
    if (mode_q == LAT_PIPE) begin
      rdata  = stage2;
      rvalid = v_taps[1];
      ce_del = c_taps[1];
    end else begin
      rdata  = stage1;
      rvalid = v_taps[0];
      ce_del = c_taps[0];
    end
  end

  assign dq_oe = oe & ce_del;

  // R1: mode does not move once reset is released
  a_r1_mode_static: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q));

  // R2: flow-through read valid one edge later
  a_r2_flow_valid: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LAT_FLOW && rd_fire) |=> rvalid);

  // R3: pipelined read valid two edges later
  a_r3_pipe_valid: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LAT_PIPE && rd_fire) |-> ##2 rvalid);

  // R5: bus control follows the chip selects at the selected latency
  a_r5_flow_bus_on: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LAT_FLOW && sel) |=> ce_del);

  a_r5_pipe_bus_off: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LAT_PIPE && !sel) |-> ##2 !ce_del);

  // R9: data bus is quiet whenever no read completes
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> $stable(rdata));
endmodule

// File: tb/sim_port_read_pipe.sv
module sim_port_read_pipe;
  localparam int LANES = 8;
  localparam int LW    = 9;
  localparam int AW    = 6;
  localparam int DW    = LANES * LW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pipe_sel = 1'b0;
  logic             cs_a = 1'b0, cs_b = 1'b0, oe = 1'b1, wr = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    wdata = '0;
  logic [LANES-1:0] lane_we = '0;
  logic [DW-1:0]    rdata;
  logic             rvalid, dq_oe;

  always #4 clk = ~clk;  // 125 MHz

  port_read_pipe #(.LANES(LANES), .LANE_W(LW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .pipe_sel(pipe_sel), .cs_a(cs_a), .cs_b(cs_b),
    .oe(oe), .wr(wr), .addr(addr), .wdata(wdata), .lane_we(lane_we),
    .rdata(rdata), .rvalid(rvalid), .dq_oe(dq_oe)
  );

  typedef struct {
    int            due;
    logic [DW-1:0] data;
  } exp_t;

  exp_t          sb[$];
  logic [DW-1:0] model [1 << AW];
  int            cyc = 0;
  int            lat = 1;
  int            n_chk = 0;
  int            n_bad = 0;
  logic [DW-1:0] last_rd = '0;
  bit            done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: compare results against the scoreboard on the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rvalid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R4 unexpected rvalid", {{(DW-1){1'b0}}, rvalid}, '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.due, lat == 1 ? "R2 read timing" : "R3 read timing",
              DW'(cyc), DW'(e.due));
          chk(rdata === e.data, "R8 read data", rdata, e.data);
        end
      end else if (sb.size() != 0 && sb[0].due <= cyc) begin
        chk(1'b0, lat == 1 ? "R2 missing rvalid" : "R3 missing rvalid",
            DW'(cyc), DW'(sb[0].due));
        void'(sb.pop_front());
      end
    end
  end

  // driver: one command per sampled edge
  task automatic op(input bit a, input bit b, input bit w,
                    input logic [AW-1:0] ad, input logic [DW-1:0] d,
                    input logic [LANES-1:0] we);
    @(posedge clk);
    #1;
    cs_a = a; cs_b = b; wr = w; addr = ad; wdata = d; lane_we = we;
    if (a && b && w) begin
      for (int i = 0; i < LANES; i++)
        if (we[i]) model[ad][i*LW +: LW] = d[i*LW +: LW];
    end
    if (a && b && !w) begin
      exp_t e;
      e.due  = cyc + lat;
      e.data = model[ad];
      sb.push_back(e);
      last_rd = model[ad];
    end
  endtask

  task automatic idle(input int n);
    op(1'b0, 1'b0, 1'b0, '0, '0, '0);
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic do_reset(input bit m);
    @(posedge clk);
    #1;
    rst = 1'b1; pipe_sel = m; cs_a = 1'b1; cs_b = 1'b1; oe = 1'b1; wr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rvalid == 1'b0, "R10 rvalid in reset", DW'(rvalid), '0);
    chk(dq_oe == 1'b0, "R10 dq_oe in reset", DW'(dq_oe), '0);
    chk(rdata == '0, "R10 rdata in reset", rdata, '0);
    @(posedge clk);
    #1;
    rst = 1'b0; cs_a = 1'b0; cs_b = 1'b0;
    pipe_sel = ~m;  // R1: flipped after release, must be ignored
    lat = m ? 2 : 1;
    sb.delete();
    @(negedge clk);
    chk(rvalid == 1'b0 && dq_oe == 1'b0, "R10 outputs after release",
        DW'({rvalid, dq_oe}), '0);
  endtask

  task automatic bus_check;
    int c;
    // enable: write with no lanes keeps cs active without a read
    op(1'b1, 1'b1, 1'b1, '0, '0, '0);
    c = cyc;
    for (int k = 0; k <= lat; k++) begin
      @(negedge clk);
      chk(dq_oe == (cyc - c >= lat), "R5 bus enable delay",
          DW'(dq_oe), DW'(cyc - c >= lat));
    end
    oe = 1'b0;
    #1;
    chk(dq_oe == 1'b0, "R6 oe gates bus at once", DW'(dq_oe), '0);
    oe = 1'b1;
    #1;
    chk(dq_oe == 1'b1, "R6 oe restores bus", DW'(dq_oe), 1);
    op(1'b0, 1'b0, 1'b0, '0, '0, '0);
    c = cyc;
    for (int k = 0; k <= lat; k++) begin
      @(negedge clk);
      chk(dq_oe == (cyc - c < lat), "R5 bus disable delay",
          DW'(dq_oe), DW'(cyc - c < lat));
    end
  endtask

  task automatic run_mode(input bit m);
    logic [DW-1:0] pat;
    do_reset(m);
    // fill some words with full writes
    for (int a = 0; a < 6; a++) begin
      pat = {8{9'(a * 37 + 5 + m)}};
      op(1'b1, 1'b1, 1'b1, AW'(a), pat, '1);
    end
    // back-to-back reads, latency follows the mode captured at reset (R1)
    for (int a = 0; a < 6; a++) op(1'b1, 1'b1, 1'b0, AW'(a), '0, 8'h00);
    idle(4);
    // R9: data held while idle
    chk(rdata == last_rd, "R9 rdata held when idle", rdata, last_rd);
    @(negedge clk);
    chk(rvalid == 1'b0 && rdata == last_rd, "R9 rdata held next cycle",
        rdata, last_rd);
    // R7: partial write touches only lanes with enable set
    op(1'b1, 1'b1, 1'b1, 6'd3, {DW{1'b1}}, 8'h5A);
    op(1'b1, 1'b1, 1'b0, 6'd3, '0, 8'hFF);  // R8 read ignores lane_we
    idle(4);
    chk(last_rd[LW +: LW] == '1 && last_rd[0 +: LW] == 9'(3 * 37 + 5 + m),
        "R7 lane model", last_rd, last_rd);
    // R4: write with one select low is ignored
    op(1'b1, 1'b0, 1'b1, 6'd3, '0, '1);
    op(1'b0, 1'b1, 1'b1, 6'd4, '0, '1);
    op(1'b1, 1'b1, 1'b0, 6'd3, '0, '0);
    op(1'b1, 1'b1, 1'b0, 6'd4, '0, '0);
    // R4: read with one select low gives no rvalid
    op(1'b1, 1'b0, 1'b0, 6'd1, '0, '0);
    idle(4);
    chk(sb.size() == 0, "R4 scoreboard drained", DW'(sb.size()), '0);
    bus_check();
    idle(3);
  endtask

  initial begin
    fork
      begin
        run_mode(1'b0);
        run_mode(1'b1);
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", '0, '0);
      end
    join_any
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule